// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit multiplies two 32-bit integers and leaves a 64-bit result in a register pair. The upper word sits in HI and the lower word in LO. Six operations are provided: a plain multiply, a multiply that adds the product to the current HI:LO value, and a multiply that subtracts the product from it. Each comes in a signed and an unsigned form. In the accumulating forms HI:LO is read as a single 64-bit quantity, and the 64-bit result wraps modulo 2^64.

A request is issued by pulsing `start` with the operands and a 3-bit operation code on the same cycle. `busy` acts as the inverse of a ready signal. A request is accepted only on a cycle when `busy` is low. A request made while `busy` is high is dropped and is not held back for later, so the issuer must wait for `busy` to fall before retrying. Every operation takes four cycles, and completion is marked by a one-cycle `done` pulse. While the unit is idle, a host can load HI or LO directly through a shared write-data port.

Top module: `hilo_mac_unit`

## Requirements
- R1: After reset, HI, LO, `busy` and `done` are all zero.
- R2: Code 000 sign-extends both operands and loads the 64-bit product into HI:LO, with the upper word in HI.
- R3: Code 001 zero-extends both operands and loads the 64-bit product into HI:LO.
- R4: Code 010 adds the signed 64-bit product to HI:LO, wrapping modulo 2^64.
- R5: Code 011 adds the unsigned 64-bit product to HI:LO, wrapping modulo 2^64.
- R6: Code 100 subtracts the signed product from HI:LO, and code 101 subtracts the unsigned product. Both wrap modulo 2^64.
- R7: After an accepted start, `busy` is high for exactly 4 cycles, starting on the cycle after the start. On the cycle `busy` falls, HI:LO shows the result and `done` is high for that one cycle only.
- R8: A `start` that arrives while `busy` is high has no effect on the operation in flight or on its result.
- R9: Codes 110 and 111 are ignored. `busy` stays low and HI and LO do not change.
- R10: `hi_wr_en` or `lo_wr_en` loads `wr_data` into HI or LO on the next cycle when the unit is idle. While `busy` is high, both are ignored.
- R11: An accumulating operation reads HI:LO as it stands when the result is written. This includes a host write made on the same cycle as the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when `busy` is low |
| op | input | 3 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| hi_wr_en | input | 1 | Direct load of HI |
| lo_wr_en | input | 1 | Direct load of LO |
| wr_data | input | 32 | Data for direct loads |
| hi | output | 32 | Upper result word |
| lo | output | 32 | Lower result word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the internal state goes wrong, it shows at the ports within one operation.

- A miscounted latency or a stuck sequencer shifts the falling edge of `busy` or the `done` pulse. Both are compared on every cycle.
- A wrong sign-extension choice or a wrong accumulate mode gives a wrong HI:LO value on the cycle `done` rises.
- A host write that leaks through during `busy` changes HI or LO mid-operation, and this is caught on the very next cycle.
- A stale HI:LO snapshot used by an accumulate only becomes visible when the result lands. The bench therefore loads HI:LO on the same cycle as the start.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_SUB  = 2'd2
  } acc_mode_e;

  typedef struct packed {
    logic      is_signed;
    acc_mode_e acc;
  } op_dec_t;

  // Codes 0..5 are legal; 6 and 7 are dropped.
  function automatic logic op_legal(input logic [2:0] code);
    return code < 3'd6;
  endfunction

  // bit0 selects unsigned, bits [2:1] select plain / add / subtract
  function automatic op_dec_t op_decode(input logic [2:0] code);
    op_dec_t d;
    d.is_signed = ~code[0];
    case (code[2:1])
      2'b01:   d.acc = ACC_ADD;
      2'b10:   d.acc = ACC_SUB;
      default: d.acc = ACC_NONE;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/hilo_mac_seq.sv
module hilo_mac_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_ok,
  output logic accept,
  output logic first,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LATENCY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  assign accept = start && op_ok && !busy_q;
  assign first  = busy_q && (cnt_q == '0);
  assign last   = busy_q && (cnt_q == LAST_CNT);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hilo_mac_arith.sv
module hilo_mac_arith
  import hilo_mac_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               first,
  input  op_dec_t            dec,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic [2*WIDTH-1:0] acc_in,
  output logic [2*WIDTH-1:0] result
);
  localparam int XW = WIDTH + 1;
  localparam int PW = 2 * XW;

  logic [XW-1:0]      a_q, b_q;
  op_dec_t            dec_q;
  logic [2*WIDTH-1:0] prod_q;

  logic signed [PW-1:0] a_wide, b_wide, full;

  assign a_wide = {{XW{a_q[XW-1]}}, a_q};
  assign b_wide = {{XW{b_q[XW-1]}}, b_q};
  assign full   = a_wide * b_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      dec_q  <= '{is_signed: 1'b0, acc: ACC_NONE};
      prod_q <= '0;
    end else begin
      if (capture) begin
        a_q   <= {dec.is_signed & a[WIDTH-1], a};
        b_q   <= {dec.is_signed & b[WIDTH-1], b};
        dec_q <= dec;
      end
      if (first) prod_q <= full[2*WIDTH-1:0];
    end
  end

  always_comb begin
    case (dec_q.acc)
      ACC_ADD: result = acc_in + prod_q;
      ACC_SUB: result = acc_in - prod_q;
      default: result = prod_q;
    endcase
  end
endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_mac_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic             hi_wr_en,
  input  logic             lo_wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             busy,
  output logic             done
);
  logic               accept, first, last;
  logic [WIDTH-1:0]   hi_q, lo_q;
  logic [2*WIDTH-1:0] result;

  hilo_mac_seq #(.LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_ok(op_legal(op)),
    .accept(accept), .first(first), .last(last), .busy(busy), .done(done)
  );

  hilo_mac_arith #(.WIDTH(WIDTH)) u_arith (
    .clk(clk), .rst_n(rst_n), .capture(accept), .first(first),
    .dec(op_decode(op)), .a(src_a), .b(src_b),
    .acc_in({hi_q, lo_q}), .result(result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last) begin
      {hi_q, lo_q} <= result;
    end else if (!busy) begin
      if (hi_wr_en) hi_q <= wr_data;
      if (lo_wr_en) lo_q <= wr_data;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;
endmodule

// File: rtl/hilo_mac_chk.sv
module hilo_mac_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic             hi_wr_en,
  input logic             lo_wr_en,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo
);
  // R7
  done_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R7
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op < 3'd6) |=> busy);
  // R9
  bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op >= 3'd6) |=> !busy);
  // R10
  busy_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (hi_wr_en || lo_wr_en)) |=> (done || ($stable(hi) && $stable(lo))));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hi_wr_en && !lo_wr_en) |=> ($stable(hi) && $stable(lo)));
  // R8
  restart_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind hilo_mac_unit hilo_mac_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op),
  .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en),
  .busy(busy), .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_hilo_mac_unit.sv
`timescale 1ns/1ps
module tb_hilo_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0, wr_data = '0;
  logic        hi_wr_en = 1'b0, lo_wr_en = 1'b0;
  logic [31:0] hi, lo;
  logic        busy, done;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #2.5 clk = ~clk;

  hilo_mac_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .hi_wr_en(hi_wr_en), .lo_wr_en(lo_wr_en),
    .wr_data(wr_data), .hi(hi), .lo(lo), .busy(busy), .done(done)
  );

  // behavioural reference
  logic [31:0] m_hi, m_lo, m_a, m_b;
  logic [2:0]  m_op;
  bit          m_busy, m_done;
  int          m_cnt;

  always @(posedge clk) begin
    logic [63:0] p, acc;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 4) begin
          if (m_op[0]) p = {32'b0, m_a} * {32'b0, m_b};
          else         p = longint'($signed(m_a)) * longint'($signed(m_b));
          acc = {m_hi, m_lo};
          case (m_op >> 1)
            0: acc = p;
            1: acc = acc + p;
            default: acc = acc - p;
          endcase
          {m_hi, m_lo} = acc;
          m_busy = 0; m_done = 1;
        end
      end else begin
        if (hi_wr_en) m_hi = wr_data;
        if (lo_wr_en) m_lo = wr_data;
        if (start && op < 6) begin
          m_op = op; m_a = src_a; m_b = src_b; m_busy = 1; m_cnt = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_chk++;
      if (hi !== m_hi || lo !== m_lo || busy !== m_busy || done !== m_done) begin
        n_err++;
        $display("FAIL %s: hi=%h lo=%h busy=%b done=%b expected hi=%h lo=%h busy=%b done=%b",
                 cur_req, hi, lo, busy, done, m_hi, m_lo, m_busy, m_done);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1; op = c; src_a = a; src_b = b;
    @(negedge clk);
    start = 0;
  endtask

  task automatic load(input logic h, input logic l, input logic [31:0] d);
    @(negedge clk);
    hi_wr_en = h; lo_wr_en = l; wr_data = d;
    @(negedge clk);
    hi_wr_en = 0; lo_wr_en = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", {hi, lo}, 64'h0);
    chk("R1", {62'b0, busy, done}, 64'h0);

    cur_req = "R2";
    issue(3'b000, 32'hFFFF_FFFD, 32'd7); settle();
    chk("R2", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFEB);

    cur_req = "R3";
    issue(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF); settle();
    chk("R3", {hi, lo}, 64'hFFFF_FFFE_0000_0001);

    cur_req = "R4";
    load(1, 0, 32'd0); load(0, 1, 32'd5);
    issue(3'b010, 32'hFFFF_FFFF, 32'd1); settle();
    chk("R4", {hi, lo}, 64'd4);

    cur_req = "R5";
    load(1, 1, 32'hFFFF_FFFF);
    issue(3'b011, 32'd1, 32'd1); settle();
    chk("R5", {hi, lo}, 64'd0);

    cur_req = "R6";
    issue(3'b101, 32'd1, 32'd1); settle();
    chk("R6", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    load(1, 1, 32'd0);
    issue(3'b100, 32'hFFFF_FFFE, 32'd3); settle();
    chk("R6", {hi, lo}, 64'd6);

    cur_req = "R7";
    issue(3'b001, 32'd9, 32'd9);
    chk("R7", {63'b0, busy}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R7", {62'b0, busy, done}, 64'b10);
    @(negedge clk);
    chk("R7", {62'b0, busy, done}, 64'b01);
    chk("R7", {hi, lo}, 64'd81);

    cur_req = "R8";
    issue(3'b001, 32'd3, 32'd3);
    @(negedge clk); start = 1; op = 3'b000; src_a = 32'd100; src_b = 32'd100;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk("R8", {hi, lo}, 64'd9);

    cur_req = "R9";
    issue(3'b110, 32'd2, 32'd2);
    chk("R9", {63'b0, busy}, 64'd0);
    issue(3'b111, 32'd2, 32'd2); settle();
    chk("R9", {hi, lo}, 64'd9);

    cur_req = "R10";
    issue(3'b000, 32'd2, 32'd3);
    load(1, 1, 32'hDEAD_BEEF);
    chk("R10", {hi, lo}, 64'd9);
    settle();
    chk("R10", {hi, lo}, 64'd6);

    cur_req = "R11";
    @(negedge clk);
    start = 1; op = 3'b011; src_a = 32'd2; src_b = 32'd2;
    hi_wr_en = 1; wr_data = 32'h0000_0010;
    @(negedge clk);
    start = 0; hi_wr_en = 0;
    settle();
    chk("R11", {hi, lo}, 64'h0000_0010_0000_000A);

    cur_req = "R7";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      start = $urandom_range(0, 1); op = 3'($urandom);
      src_a = $urandom; src_b = $urandom;
      hi_wr_en = ($urandom_range(0, 3) == 0); lo_wr_en = ($urandom_range(0, 3) == 0);
      wr_data = $urandom;
    end
    @(negedge clk);
    start = 0; hi_wr_en = 0; lo_wr_en = 0;
    settle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule